// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for an asynchronous 16-bit static RAM inside a clocked design. A fast system clock samples the memory-side control pins: an active-low chip enable, an active-high chip enable, active-low write enable, output enable and the two byte-lane enables. From these it works out one of four operating modes. Writes update only the byte lanes that are enabled. Reads drive stored data on the enabled lanes only. All other lanes, and the whole bus outside a read, are reported as not driven through a per-lane output-enable vector, which a pad wrapper turns into real tri-state buffers.

The control pins pass through a two-flop synchronizer. Address and write data pass through a two-flop pipeline of the same depth, so all inputs stay aligned. A write keeps the last data sampled while it was active and commits that data when the sampled write enable goes high or the chip is deselected, whichever happens first. Read data, the lane enables and the mode code appear on the third clock edge after an input change. A saturating counter records address changes seen while the chip is selected. It serves as a measure of active-power events.

Top module: `sram_byte_lane_emu`

## Requirements
- R1: When `chipSelN` is high or `chipSelHi` is low (standby), `modeCode` is 0 and `dataOe` is 0. Write, read and byte-lane inputs have no effect on memory, and address changes are not counted.
- R2: When the chip is selected and both `upperEnN` and `lowerEnN` are high, `modeCode` is 1, `dataOe` is 0, and a low `writeEnN` changes no stored data.
- R3: When the chip is selected, `writeEnN` is low and at least one lane is enabled, `modeCode` is 3 and `dataOe` is 0 whatever `outEnN` is. Only the enabled lanes of the addressed word are written: bit 15..8 is the upper lane and bit 7..0 the lower lane.
- R4: When the chip is selected, `writeEnN` is high, `outEnN` is low and at least one lane is enabled, `modeCode` is 2. `dataOe[1]` is set for the upper lane and `dataOe[0]` for the lower lane, and `dataOut` holds the stored word on those lanes.
- R5: When the chip is selected with both `writeEnN` and `outEnN` high, `modeCode` is 1 and `dataOe` is 0.
- R6: A write commits the last data and address sampled while it was active. It commits when the sampled `writeEnN` rises or the chip is deselected, whichever comes first. Inputs that change after a deselect do not alter the committed word.
- R7: Only the low log2(DEPTH) address bits select a word. Higher address bits are ignored.
- R8: `addrChanges` increments once for each sampled change of the word-select address bits while the chip is selected, and holds at its all-ones maximum.
- R9: After reset, `modeCode` is 0, `dataOe` is 0 and `addrChanges` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSelN | input | 1 | Active-low chip enable |
| chipSelHi | input | 1 | Active-high chip enable |
| writeEnN | input | 1 | Active-low write enable |
| outEnN | input | 1 | Active-low output enable |
| upperEnN | input | 1 | Active-low upper byte-lane enable |
| lowerEnN | input | 1 | Active-low lower byte-lane enable |
| addr | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data toward the bus |
| dataOe | output | 2 | Per-lane drive enable (bit 1 upper, bit 0 lower) |
| modeCode | output | 2 | 0 standby, 1 idle selected, 2 read, 3 write |
| addrChanges | output | CNT_W | Saturating count of selected address changes |

## Verification
The hardest case to reach from the ports is a write that ends by deselect rather than by write enable. Here the data, the address and the write enable must all move after the chip drops out, and the stored word must still be the one sampled before the deselect. The bench holds the write enable low, raises the active-low chip enable, and waits for the synchronizer to settle. Only then does it change the data and address and release the write enable. It then reads both addresses back. Counter saturation is reached by stepping the address every cycle for more changes than the counter can hold.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } emuMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             selected;
    logic             capture;
    logic             commit;
    logic [LANES-1:0] wrLanes;
    logic [LANES-1:0] rdLanes;
  } emuStrobes_t;
endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSelN,
  input  logic        chipSelHi,
  input  logic        writeEnN,
  input  logic        outEnN,
  input  logic        upperEnN,
  input  logic        lowerEnN,
  output emuStrobes_t strobes,
  output emuMode_t    modeCode
);
  localparam int SYNC_W = 6;
  // order: {chipSelN, chipSelHi, writeEnN, outEnN, upperEnN, lowerEnN}
  localparam logic [SYNC_W-1:0] IDLE_PINS = 6'b101111;

  logic [SYNC_W-1:0] syncA, syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= IDLE_PINS;
      syncB <= IDLE_PINS;
    end else begin
      syncA <= {chipSelN, chipSelHi, writeEnN, outEnN, upperEnN, lowerEnN};
      syncB <= syncA;
    end
  end

  logic selS, weS, oeS, anyLane, isWrite, isRead, pending, commitNow;
  logic [LANES-1:0] lanesS;

  always_comb begin
    selS      = !syncB[5] && syncB[4];
    weS       = !syncB[3];
    oeS       = !syncB[2];
    lanesS    = ~syncB[1:0];
    anyLane   = |lanesS;
    isWrite   = selS && weS && anyLane;
    isRead    = selS && !weS && oeS && anyLane;
    commitNow = pending && (!weS || !selS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pending <= 1'b0;
    else if (commitNow) pending <= 1'b0;
    else if (isWrite)   pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        modeCode <= MODE_STBY;
    else if (!selS)   modeCode <= MODE_STBY;
    else if (isWrite) modeCode <= MODE_WRITE;
    else if (isRead)  modeCode <= MODE_READ;
    else              modeCode <= MODE_IDLE;
  end

  always_comb begin
    strobes.selected = selS;
    strobes.capture  = isWrite;
    strobes.commit   = commitNow;
    strobes.wrLanes  = lanesS;
    strobes.rdLanes  = isRead ? lanesS : '0;
  end
endmodule

// File: rtl/sram_emu_data.sv
module sram_emu_data
  import sram_emu_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  emuStrobes_t       strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic [LANES-1:0]  dataOe,
  output logic [CNT_W-1:0]  addrChanges
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  idxA, idxB, idxPrev, wrIdx;
  logic [DATA_W-1:0] dataA, dataB, wrData;
  logic [LANES-1:0]  wrLanesQ;

  // aligned with the two-flop control synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxA <= '0; idxB <= '0; idxPrev <= '0;
      dataA <= '0; dataB <= '0;
    end else begin
      idxA    <= addr[IDX_W-1:0];
      idxB    <= idxA;
      idxPrev <= idxB;
      dataA   <= dataIn;
      dataB   <= dataA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0; wrData <= '0; wrLanesQ <= '0;
    end else if (strobes.capture) begin
      wrIdx    <= idxB;
      wrData   <= dataB;
      wrLanesQ <= strobes.wrLanes;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.commit && wrLanesQ[g])
        laneMem[wrIdx] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dataOut[g*LANE_W +: LANE_W] <= '0;
      else       dataOut[g*LANE_W +: LANE_W] <= laneMem[idxB];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOe <= '0;
    else       dataOe <= strobes.rdLanes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      addrChanges <= '0;
    else if (strobes.selected && (idxB != idxPrev) && (addrChanges != {CNT_W{1'b1}}))
      addrChanges <= addrChanges + 1'b1;
  end

  assert_cnt_sticks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addrChanges == {CNT_W{1'b1}}) |=> (addrChanges == {CNT_W{1'b1}}));

  assert_cnt_single_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addrChanges == $past(addrChanges)) || (addrChanges == $past(addrChanges) + 1'b1));
endmodule

// File: rtl/sram_byte_lane_emu.sv
module sram_byte_lane_emu
  import sram_emu_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              chipSelHi,
  input  logic              writeEnN,
  input  logic              outEnN,
  input  logic              upperEnN,
  input  logic              lowerEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        dataOe,
  output logic [1:0]        modeCode,
  output logic [CNT_W-1:0]  addrChanges
);
  emuStrobes_t strobes;
  emuMode_t    modeQ;

  sram_emu_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .chipSelN(chipSelN), .chipSelHi(chipSelHi),
    .writeEnN(writeEnN), .outEnN(outEnN),
    .upperEnN(upperEnN), .lowerEnN(lowerEnN),
    .strobes(strobes), .modeCode(modeQ)
  );

  sram_emu_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN),
    .addr(addr), .dataIn(dataIn), .strobes(strobes),
    .dataOut(dataOut), .dataOe(dataOe), .addrChanges(addrChanges)
  );

  assign modeCode = modeQ;

  assert_standby_no_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_STBY) |-> (dataOe == 2'b00));

  assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_IDLE) |-> (dataOe == 2'b00));

  assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_WRITE) |-> (dataOe == 2'b00));

  assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_READ) |-> (dataOe != 2'b00));
endmodule

// File: tb/sram_byte_lane_emu_test.sv
module sram_byte_lane_emu_test;
  localparam int ADDR_W = 19;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1, chipSelHi = 1'b0, writeEnN = 1'b1, outEnN = 1'b1;
  logic upperEnN = 1'b1, lowerEnN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  dataOe, modeCode;
  logic [CNT_W-1:0] addrChanges;

  int nChecks = 0, nFails = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  sram_byte_lane_emu #(.DEPTH(1024), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSelHi(chipSelHi),
    .writeEnN(writeEnN), .outEnN(outEnN), .upperEnN(upperEnN), .lowerEnN(lowerEnN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .modeCode(modeCode), .addrChanges(addrChanges)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic selectChip();
    chipSelN = 1'b0; chipSelHi = 1'b1; settle();
  endtask

  task automatic doWrite(logic [ADDR_W-1:0] a, logic [15:0] d, logic ub, logic lb);
    addr = a; dataIn = d; upperEnN = ub; lowerEnN = lb; outEnN = 1'b1;
    writeEnN = 1'b0; settle();
    writeEnN = 1'b1; settle();
  endtask

  task automatic doRead(logic [ADDR_W-1:0] a, logic ub, logic lb);
    writeEnN = 1'b1; addr = a; upperEnN = ub; lowerEnN = lb; outEnN = 1'b0;
    settle();
  endtask

  task automatic endRead();
    outEnN = 1'b1; settle();
  endtask

  task automatic applyReset();
    rstN = 1'b0; repeat (3) @(posedge clk); #1;
    rstN = 1'b1; @(posedge clk); #1;
  endtask

  task automatic testReset();
    chk("R9 mode", modeCode, 0);
    chk("R9 oe", dataOe, 0);
    chk("R9 count", addrChanges, 0);
  endtask

  task automatic testBasic();
    selectChip();
    doWrite(19'h0000A, 16'hBEEF, 1'b0, 1'b0);
    doWrite(19'h00011, 16'h1357, 1'b0, 1'b0);
    doRead(19'h0000A, 1'b0, 1'b0);
    chk("R4 mode", modeCode, 2);
    chk("R4 oe", dataOe, 2'b11);
    chk("R3 data A", dataOut, 16'hBEEF);
    doRead(19'h00011, 1'b0, 1'b0);
    chk("R3 data 11", dataOut, 16'h1357);
    endRead();
  endtask

  task automatic testLanes();
    doWrite(19'h0000A, 16'h1299, 1'b0, 1'b1);
    doRead(19'h0000A, 1'b0, 1'b0);
    chk("R3 upper only", dataOut, 16'h12EF);
    doRead(19'h0000A, 1'b1, 1'b0);
    chk("R4 lower oe", dataOe, 2'b01);
    chk("R4 lower data", dataOut & 16'h00FF, 16'h00EF);
    doRead(19'h0000A, 1'b0, 1'b1);
    chk("R4 upper oe", dataOe, 2'b10);
    chk("R4 upper data", dataOut & 16'hFF00, 16'h1200);
    endRead();
  endtask

  task automatic testOeDuringWrite();
    addr = 19'h00030; dataIn = 16'hC0DE; upperEnN = 1'b0; lowerEnN = 1'b0;
    outEnN = 1'b0; writeEnN = 1'b0; settle();
    chk("R3 mode while oe low", modeCode, 3);
    chk("R3 no drive while oe low", dataOe, 0);
    writeEnN = 1'b1; settle();
    chk("R4 read after write", dataOut, 16'hC0DE);
    endRead();
  endtask

  task automatic testIdle();
    chk("R5 idle mode", modeCode, 1);
    chk("R5 idle oe", dataOe, 0);
    doRead(19'h00030, 1'b1, 1'b1);
    chk("R2 mode no lanes", modeCode, 1);
    chk("R2 oe no lanes", dataOe, 0);
    endRead();
    doWrite(19'h00030, 16'h0000, 1'b1, 1'b1);
    doRead(19'h00030, 1'b0, 1'b0);
    chk("R2 no write without lanes", dataOut, 16'hC0DE);
    endRead();
  endtask

  task automatic testStandby();
    chipSelN = 1'b1; settle();
    outEnN = 1'b0; upperEnN = 1'b0; lowerEnN = 1'b0; addr = 19'h0000A; settle();
    chk("R1 mode csn", modeCode, 0);
    chk("R1 oe csn", dataOe, 0);
    dataIn = 16'h0000; writeEnN = 1'b0; settle(); writeEnN = 1'b1; settle();
    outEnN = 1'b1;
    chipSelN = 1'b0; chipSelHi = 1'b0; settle();
    chk("R1 mode cshi", modeCode, 0);
    writeEnN = 1'b0; settle(); writeEnN = 1'b1; settle();
    selectChip();
    doRead(19'h0000A, 1'b0, 1'b0);
    chk("R1 standby write ignored", dataOut, 16'h12EF);
    endRead();
  endtask

  task automatic testDeselectCommit();
    doWrite(19'h00021, 16'h0000, 1'b0, 1'b0);
    addr = 19'h00020; dataIn = 16'h1111; upperEnN = 1'b0; lowerEnN = 1'b0;
    writeEnN = 1'b0; settle();
    dataIn = 16'h5A5A; settle();
    chipSelN = 1'b1; settle();
    dataIn = 16'hFFFF; addr = 19'h00021; settle();
    writeEnN = 1'b1; settle();
    selectChip();
    doRead(19'h00020, 1'b0, 1'b0);
    chk("R6 last data on deselect", dataOut, 16'h5A5A);
    doRead(19'h00021, 1'b0, 1'b0);
    chk("R6 late inputs ignored", dataOut, 16'h0000);
    endRead();
  endtask

  task automatic testUpperAddr();
    doWrite(19'h40033, 16'h7777, 1'b0, 1'b0);
    doRead(19'h00033, 1'b0, 1'b0);
    chk("R7 upper bits ignored", dataOut, 16'h7777);
    endRead();
  endtask

  task automatic testCounter();
    addr = '0; applyReset();
    chk("R9 count after reset", addrChanges, 0);
    selectChip();
    addr = 19'h00001; settle();
    addr = 19'h00002; settle();
    addr = 19'h00003; settle();
    chk("R8 three changes", addrChanges, 3);
    chipSelN = 1'b1; settle();
    addr = 19'h00004; settle();
    addr = 19'h00005; settle();
    selectChip();
    chk("R1 standby not counted", addrChanges, 3);
    addr = 19'h40005; settle();
    chk("R7 upper change not counted", addrChanges, 3);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      addr = 19'(10 + i);
    end
    settle();
    chk("R8 saturation", addrChanges, 255);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1; @(posedge clk); #1;
    testReset();
    testBasic();
    testLanes();
    testOeDuringWrite();
    testIdle();
    testStandby();
    testDeselectCommit();
    testUpperAddr();
    testCounter();
    doneFlag = 1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule